// File: doc/BRIEF.md
# Segment Register Emulation over a Segment Lookaside Buffer

This block lets software that still uses the legacy 32-bit segment register moves run on a core whose segment state lives in a 64-bit segment lookaside buffer. Each request is either a move-to or a move-from of segment register n. The segment number comes either from a direct field or, in the indirect forms, from the top four bits of a 32-bit address operand. A move-to repacks the 32-bit source value into the buffer's split entry layout and marks the entry valid. The effective segment id of that entry is the segment number. A move-from unpacks a valid entry back into the 32-bit register view.

Both directions are supervisor-only. A request that arrives without supervisor privilege returns a privilege fault and leaves the buffer untouched. The block accepts one request in every cycle, back to back, and answers each one with a registered response in the following cycle.

A small state machine holds the kind of response now on the outputs. ST_IDLE means no response. ST_READ_RSP, ST_WRITE_RSP and ST_FAULT_RSP each present the answer to a supervisor read, a supervisor write or a refused request. The next state depends only on the request sampled at the edge. The transitions are TR_NONE (no request, to ST_IDLE), TR_READ (supervisor move-from, to ST_READ_RSP), TR_WRITE (supervisor move-to, to ST_WRITE_RSP) and TR_DENY (any request without privilege, to ST_FAULT_RSP). Any state may take any of the four transitions.

Top module: `segreg_slb_map`

## Requirements
- R1: While reset is asserted rsp_valid is 0. After reset every entry is invalid, so a move-from of any entry returns zero.
- R2: A supervisor move-to of value S into entry n stores a low word equal to {S[23:0], S[30:27], 4'b0000} and a high part whose bits [2:0] are S[26:24], with the valid flag set and the segment id equal to n. A following move-from of n shows this as S with bit 31 cleared.
- R3: A move-from of a valid entry returns {1'b0, low[7:4], high[2:0], low[31:8]}. Bit 31 of any read result is 0.
- R4: A move-from of an entry whose valid flag is clear returns zero with rsp_fault 0.
- R5: When req_indirect is 1 the segment number is req_addr[31:28] and req_segnum is ignored. The indirect forms therefore reach only entries 0 to 15.
- R6: A request with req_super 0 gives rsp_fault 1 and rsp_data 0, and it changes no entry.
- R7: rsp_valid is 1 in exactly the cycle after a request is sampled (req_valid 1 at a rising edge) and 0 otherwise, including for back-to-back requests. A move-from issued in the cycle after a move-to of the same entry sees the new value.
- R8: A supervisor move-to answers with rsp_fault 0 and rsp_data 0.
- R9: A move-to of entry n changes no other entry.
- R10: The direct segment field is wide enough to address every entry, including the last one (index 31 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | A request is present this cycle |
| req_write | input | 1 | 1 = move-to (write entry), 0 = move-from (read entry) |
| req_indirect | input | 1 | 1 = segment number taken from req_addr[31:28] |
| req_segnum | input | IDX_W (5) | Direct segment number |
| req_addr | input | 32 | Address operand for the indirect forms |
| req_src | input | 32 | Source value for move-to |
| req_super | input | 1 | Request issued with supervisor privilege |
| rsp_valid | output | 1 | Response present, one cycle after the request |
| rsp_data | output | 32 | Read result, zero for writes and faults |
| rsp_fault | output | 1 | Privileged-register fault |

## Verification
Every result of this block is due exactly one rising edge after the request is sampled. This covers the read data, the fault flag and the zero data of a write. A stored entry becomes visible to a request sampled at the very next edge. The bench drives inputs on falling edges. Its behavioural model takes each rising edge and computes the response due at that edge, along with the entry state that the next request will see. The outputs are then compared on the following falling edge, so every cycle is checked, idle and reset cycles included. Each compare carries the requirement tag of the request that produced it.

// File: rtl/slbmap_pkg.sv
package slbmap_pkg;

    localparam int WORD_W    = 32;
    localparam int SEG_BITS  = 4;
    localparam int SEG_SHIFT = WORD_W - SEG_BITS;
    localparam int LO_SHIFT  = 8;
    localparam int HI_TAIL_W = 3;

    // Compact form of one buffer entry. The high part only ever holds the
    // valid flag, the tail bits [2:0] and the segment id; the id equals the
    // entry position and is therefore implied by where the entry sits.
    typedef struct packed {
        logic                  valid;
        logic [HI_TAIL_W-1:0]  hi_tail;
        logic [WORD_W-1:0]     lo_word;
    } slb_entry_t;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_READ_RSP  = 2'd1,
        ST_WRITE_RSP = 2'd2,
        ST_FAULT_RSP = 2'd3
    } rsp_state_e;

endpackage

// File: rtl/slbmap_req_decode.sv
module slbmap_req_decode
    import slbmap_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_indirect,
    input  logic [IDX_W-1:0]  req_segnum,
    input  logic [WORD_W-1:0] req_addr,
    input  logic              req_super,
    output logic [IDX_W-1:0]  sel_idx,
    output logic              do_read,
    output logic              do_write,
    output logic              do_deny
);

    logic [IDX_W-1:0] ind_idx;
    logic             unused_addr_low;

    assign unused_addr_low = ^req_addr[SEG_SHIFT-1:0];

    // Indirect segment number: top bits of the address operand, sized to
    // the index width chosen by the entry count.
    generate
        if (IDX_W > SEG_BITS) begin : g_widen
            assign ind_idx = {{(IDX_W-SEG_BITS){1'b0}}, req_addr[WORD_W-1:SEG_SHIFT]};
        end else if (IDX_W == SEG_BITS) begin : g_exact
            assign ind_idx = req_addr[WORD_W-1:SEG_SHIFT];
        end else begin : g_narrow
            logic unused_addr_high;
            assign unused_addr_high = ^req_addr[WORD_W-1:SEG_SHIFT+IDX_W];
            assign ind_idx = req_addr[SEG_SHIFT+IDX_W-1:SEG_SHIFT];
        end
    endgenerate

    always_comb begin
        sel_idx  = req_indirect ? ind_idx : req_segnum;
        do_deny  = req_valid && !req_super;
        do_write = req_valid &&  req_super &&  req_write;
        do_read  = req_valid &&  req_super && !req_write;
    end

endmodule

// File: rtl/slbmap_field_pack.sv
module slbmap_field_pack
    import slbmap_pkg::*;
(
    input  logic [WORD_W-1:0] src_word,
    input  slb_entry_t        rd_entry,
    output slb_entry_t        wr_entry,
    output logic [WORD_W-1:0] rd_word
);

    logic unused_src_top;
    logic unused_lo_nibble;

    assign unused_src_top   = src_word[WORD_W-1];
    assign unused_lo_nibble = ^rd_entry.lo_word[3:0];

    // Register view -> entry layout.
    always_comb begin
        wr_entry.valid   = 1'b1;
        wr_entry.hi_tail = src_word[26:24];
        wr_entry.lo_word = {src_word[23:0], src_word[30:27], 4'b0000};
    end

    // Entry layout -> register view; an invalid entry reads as zero.
    always_comb begin
        if (rd_entry.valid) begin
            rd_word = {1'b0,
                       rd_entry.lo_word[7:4],
                       rd_entry.hi_tail,
                       rd_entry.lo_word[WORD_W-1:LO_SHIFT]};
        end else begin
            rd_word = '0;
        end
    end

endmodule

// File: rtl/slbmap_entry_array.sv
module slbmap_entry_array
    import slbmap_pkg::*;
#(
    parameter int NUM_ENTRIES = 32,
    parameter int IDX_W       = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  slb_entry_t       wr_entry,
    input  logic [IDX_W-1:0] rd_idx,
    output slb_entry_t       rd_entry
);

    slb_entry_t store [NUM_ENTRIES];

    generate
        for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_entry
            localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g);
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    store[g].valid <= 1'b0;
                end else if (wr_en && (wr_idx == MY_IDX)) begin
                    store[g] <= wr_entry;
                end
            end
        end
    endgenerate

    // An index past the last entry selects nothing and reads as invalid.
    always_comb begin
        rd_entry = '0;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            if (rd_idx == IDX_W'(i)) begin
                rd_entry = store[i];
            end
        end
    end

endmodule

// File: rtl/segreg_slb_map.sv
module segreg_slb_map
    import slbmap_pkg::*;
#(
    parameter int NUM_ENTRIES = 32,
    localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_indirect,
    input  logic [IDX_W-1:0]  req_segnum,
    input  logic [WORD_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_src,
    input  logic              req_super,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_data,
    output logic              rsp_fault
);

    logic [IDX_W-1:0]  sel_idx;
    logic              do_read;
    logic              do_write;
    logic              do_deny;
    slb_entry_t        wr_entry;
    slb_entry_t        rd_entry;
    logic [WORD_W-1:0] rd_word;

    rsp_state_e        state_q;
    rsp_state_e        state_d;
    logic [WORD_W-1:0] data_q;

    slbmap_req_decode #(
        .IDX_W (IDX_W)
    ) u_decode (
        .req_valid    (req_valid),
        .req_write    (req_write),
        .req_indirect (req_indirect),
        .req_segnum   (req_segnum),
        .req_addr     (req_addr),
        .req_super    (req_super),
        .sel_idx      (sel_idx),
        .do_read      (do_read),
        .do_write     (do_write),
        .do_deny      (do_deny)
    );

    slbmap_field_pack u_pack (
        .src_word (req_src),
        .rd_entry (rd_entry),
        .wr_entry (wr_entry),
        .rd_word  (rd_word)
    );

    slbmap_entry_array #(
        .NUM_ENTRIES (NUM_ENTRIES),
        .IDX_W       (IDX_W)
    ) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (do_write),
        .wr_idx   (sel_idx),
        .wr_entry (wr_entry),
        .rd_idx   (sel_idx),
        .rd_entry (rd_entry)
    );

    // Transition choice: TR_DENY, TR_WRITE, TR_READ or TR_NONE, open from
    // every state since each cycle carries an independent request.
    always_comb begin
        if (do_deny) begin
            state_d = ST_FAULT_RSP;
        end else if (do_write) begin
            state_d = ST_WRITE_RSP;
        end else if (do_read) begin
            state_d = ST_READ_RSP;
        end else begin
            state_d = ST_IDLE;
        end
    end

    // State register plus the read data that accompanies ST_READ_RSP.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            data_q  <= do_read ? rd_word : '0;
        end
    end

    // Output decode.
    always_comb begin
        rsp_valid = 1'b0;
        rsp_fault = 1'b0;
        rsp_data  = '0;
        unique case (state_q)
            ST_IDLE: begin
                rsp_valid = 1'b0;
            end
            ST_READ_RSP: begin
                rsp_valid = 1'b1;
                rsp_data  = data_q;
            end
            ST_WRITE_RSP: begin
                rsp_valid = 1'b1;
            end
            ST_FAULT_RSP: begin
                rsp_valid = 1'b1;
                rsp_fault = 1'b1;
            end
            default: begin
                rsp_valid = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/slbmap_checker.sv
module slbmap_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_write,
    input logic        req_super,
    input logic        rsp_valid,
    input logic [31:0] rsp_data,
    input logic        rsp_fault
);

    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R7

    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R7

    AST_USER_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_super) |=> (rsp_fault && rsp_data == 32'd0)); // R6

    AST_SUPER_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_super) |=> !rsp_fault); // R6

    AST_WRITE_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_super && req_write) |=> (rsp_data == 32'd0)); // R8

    AST_READ_TOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !rsp_data[31]); // R3

    AST_FAULT_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> rsp_valid); // R6

endmodule

bind segreg_slb_map slbmap_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_super (req_super),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .rsp_fault (rsp_fault)
);

// File: tb/segreg_slb_map_test.sv
`timescale 1ns/1ps
module segreg_slb_map_test;

    localparam int N     = 32;
    localparam int IDX_W = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_write = 1'b0;
    logic             req_indirect = 1'b0;
    logic [IDX_W-1:0] req_segnum = '0;
    logic [31:0]      req_addr = '0;
    logic [31:0]      req_src = '0;
    logic             req_super = 1'b0;
    logic             rsp_valid;
    logic [31:0]      rsp_data;
    logic             rsp_fault;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    string cur_tag = "R1";
    string exp_tag = "R1";
    bit    exp_valid = 0;
    bit    exp_fault = 0;
    logic [31:0] exp_data = '0;
    bit    started = 0;

    bit          m_valid [N];
    logic [31:0] m_value [N];

    always #4 clk = ~clk;

    segreg_slb_map #(.NUM_ENTRIES(N)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_write    (req_write),
        .req_indirect (req_indirect),
        .req_segnum   (req_segnum),
        .req_addr     (req_addr),
        .req_src      (req_src),
        .req_super    (req_super),
        .rsp_valid    (rsp_valid),
        .rsp_data     (rsp_data),
        .rsp_fault    (rsp_fault)
    );

    // Behavioural reference: what the response due at this edge must be.
    always @(posedge clk) begin
        int idx;
        started = 1;
        exp_tag = cur_tag;
        exp_valid = 0;
        exp_fault = 0;
        exp_data = 0;
        if (!rst_n) begin
            for (int i = 0; i < N; i++) m_valid[i] = 0;
        end else if (req_valid) begin
            idx = req_indirect ? int'(req_addr >> 28) : int'(req_segnum);
            exp_valid = 1;
            if (!req_super) begin
                exp_fault = 1;
            end else if (req_write) begin
                m_valid[idx] = 1;
                m_value[idx] = req_src;
            end else if (m_valid[idx]) begin
                exp_data = m_value[idx] & 32'h7FFF_FFFF;
            end
        end
    end

    always @(negedge clk) begin
        if (started && !done) begin
            checks++;
            if (rsp_valid !== exp_valid || rsp_fault !== exp_fault || rsp_data !== exp_data) begin
                errors++;
                $display("FAIL %s: valid/fault/data actual %0b/%0b/%h expected %0b/%0b/%h",
                         exp_tag, rsp_valid, rsp_fault, rsp_data, exp_valid, exp_fault, exp_data);
            end
        end
    end

    task automatic issue(input string tag, input bit wr, input bit ind,
                         input int seg, input logic [31:0] addr,
                         input logic [31:0] src, input bit sup);
        @(negedge clk);
        cur_tag      = tag;
        req_valid    = 1;
        req_write    = wr;
        req_indirect = ind;
        req_segnum   = IDX_W'(seg);
        req_addr     = addr;
        req_src      = src;
        req_super    = sup;
    endtask

    task automatic idle(input string tag);
        @(negedge clk);
        cur_tag   = tag;
        req_valid = 0;
    endtask

    task automatic finish_run;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            finish_run();
        end
    end

    initial begin
        // R1: outputs quiet during reset, every entry invalid after it
        repeat (4) @(negedge clk);
        rst_n = 1;
        for (int i = 0; i < N; i++) issue("R1", 0, 0, i, 0, 0, 1);
        idle("R7");
        // R2 / R8: write then read back the repacked value
        issue("R8", 1, 0, 3, 0, 32'hDEAD_BEEF, 1);
        issue("R2", 0, 0, 3, 0, 0, 1);
        idle("R7");
        // R10: last entry through the direct field
        issue("R10", 1, 0, 31, 0, 32'hFFFF_FFFF, 1);
        issue("R10", 0, 0, 31, 0, 0, 1);
        // R9: a single write leaves the other entries alone
        issue("R9", 1, 0, 5, 0, 32'h1234_5678, 1);
        for (int i = 0; i < N; i++) issue("R9", 0, 0, i, 0, 0, 1);
        // R6: user requests fault and change nothing
        issue("R6", 1, 0, 3, 0, 32'h0000_0000, 0);
        issue("R6", 1, 0, 7, 0, 32'h5555_5555, 0);
        issue("R6", 0, 0, 3, 0, 0, 0);
        issue("R6", 0, 0, 3, 0, 0, 1);
        issue("R6", 0, 0, 7, 0, 0, 1);
        // R5: indirect forms use addr[31:28], ignore the direct field
        issue("R5", 1, 1, 30, 32'hA000_0000, 32'h0ABC_DEF0, 1);
        issue("R5", 0, 0, 10, 0, 0, 1);
        issue("R5", 0, 0, 30, 0, 0, 1);
        issue("R5", 0, 1, 0, 32'h3FFF_FFFF, 0, 1);
        issue("R5", 0, 1, 31, 32'hF123_4567, 0, 1);
        // R4: invalid entries read zero
        issue("R4", 0, 0, 20, 0, 0, 1);
        issue("R4", 0, 1, 0, 32'hE000_0000, 0, 1);
        // R7: back-to-back write and read of the same entry
        issue("R7", 1, 0, 12, 0, 32'h8765_4321, 1);
        issue("R7", 0, 0, 12, 0, 0, 1);
        issue("R7", 1, 0, 12, 0, 32'h0F0F_F0F0, 1);
        issue("R7", 0, 0, 12, 0, 0, 1);
        idle("R7");
        idle("R7");
        // R3: mixed traffic over many field patterns
        for (int k = 0; k < 600; k++) begin
            int r = int'($urandom);
            if ((r & 7) == 0) idle("R7");
            else issue("R3", r[3], r[4], int'($urandom % N), $urandom, $urandom, (r & 31) != 5);
        end
        idle("R7");
        idle("R7");
        finish_run();
    end

endmodule